// File: doc/BRIEF.md
# Modem-Line Change Interrupt Source

This block raises an interrupt whenever the clear-to-send (CTS) modem line changes level. The CTS pin is asynchronous to the block clock. It passes through a synchronizer, and a change in either direction sets a raw status bit. A mask bit gates that status onto a masked interrupt output.

Software acknowledges the interrupt through a write-only clear bit. The clear bit loads a hidden flop. The status is cleared only when a write moves that flop from 0 to 1. Hardware returns the flop to 0 on its own once the status is low. When a line change and a clearing write land in the same cycle, the line change wins and the status stays set. The hidden flop is left at 1, so later writes of 1 no longer clear the status.

The recovery sequence is to write 0, which re-arms the flop and must stay in place for at least one clock, and then write 1.

Top module: `modem_cts_irq`

## Requirements
- R1: A rising or a falling change on `ctsAsync` sets `rawIrq` at the third rising clock edge after the input changes (two synchronizer stages plus one detection stage).
- R2: A clear write (`clrWrEn`=1, `clrWrData`=1) issued while the hidden clear flop is 0 and no line change is being recorded drops `rawIrq` at that clock edge.
- R3: A clear write of 1 issued while the hidden clear flop already holds 1 leaves `rawIrq` unchanged.
- R4: When `rawIrq` is 0 and no write is issued, the hidden clear flop returns to 0 one cycle later. After a normal clear, a later interrupt can therefore be cleared by a single write of 1.
- R5: When a line change is recorded in the same cycle as a clear write of 1, `rawIrq` stays 1. Repeated writes of 1 after that leave it at 1.
- R6: A write with `clrWrData`=0 loads 0 into the hidden flop. A write of 1 issued at least one cycle later clears `rawIrq`.
- R7: `maskedIrq` is 1 exactly when `rawIrq` and the mask bit are both 1. The mask bit is loaded from `maskWrData` when `maskWrEn` is 1. The mask never alters `rawIrq`.
- R8: Reset sets `rawIrq`, `maskedIrq`, the mask and the hidden flop to 0. It also loads the edge history with the synchronized line level, so a CTS level held through reset raises no interrupt.
- R9: While `ctsAsync` holds a constant level, `rawIrq` is never set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctsAsync | input | 1 | Asynchronous CTS modem line |
| clrWrEn | input | 1 | Write strobe for the clear bit |
| clrWrData | input | 1 | Value written to the clear bit |
| maskWrEn | input | 1 | Write strobe for the mask bit |
| maskWrData | input | 1 | Value written to the mask bit |
| rawIrq | output | 1 | Raw line-change status |
| maskedIrq | output | 1 | Status gated by the mask |

## Verification
The bench sweeps the cycle of a single clear write across the whole window around a line change, in both edge directions, and predicts `rawIrq` from that offset.

- **Collision cycle.** A design that let the clear beat the set, or that re-armed the flop on its own, would fail to lock up when the write hits the set cycle.
- **Cycles just before the set.** A design that treated the clear as level-sensitive, or that never reset the hidden flop, would lock up in those cycles or would ignore the first clear.
- **Recovery.** The write-0-then-1 sequence is checked after every offset. A design whose 0 write is ignored stays stuck.
- **Reset.** Reset is held with CTS high, which exposes a design that seeds the edge history with 0.

// File: rtl/mli_pkg.sv
package mli_pkg;
  // Strobes from the control logic to the datapath registers.
  typedef struct packed {
    logic setStat;   // record a line change
    logic clrStat;   // clear the status (0->1 on hidden flop, no set)
    logic loadClr;   // load the hidden clear flop from the write data
    logic clrVal;    // value to load
    logic dropClr;   // hardware return of the hidden flop to 0
  } mliStrobe_t;
endpackage

// File: rtl/mli_ctrl.sv
module mli_ctrl
  import mli_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       edgeSeen,
  input  logic       statusQ,
  input  logic       clrQ,
  input  logic       clrWrEn,
  input  logic       clrWrData,
  output mliStrobe_t strb
);
  logic clrRise;

  always_comb begin
    clrRise      = clrWrEn & clrWrData & ~clrQ;
    strb.setStat = edgeSeen;
    strb.clrStat = clrRise & ~edgeSeen;   // set event has priority
    strb.loadClr = clrWrEn;
    strb.clrVal  = clrWrData;
    strb.dropClr = ~clrWrEn & ~statusQ;
  end

  // R5: set beats a simultaneous clear
  p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (edgeSeen && clrWrEn && clrWrData) |=> statusQ);
  // R2/R3: status only falls after a 0->1 write on the hidden flop
  p_rise_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(statusQ) |-> $past(clrWrEn && clrWrData && !clrQ));
  // R6: writing 0 re-arms the flop
  p_arm_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clrWrEn && !clrWrData) |=> !clrQ);
  // R4: hardware return to 0 while status is low
  p_self_reset_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!statusQ && !clrWrEn) |=> !clrQ);
endmodule

// File: rtl/mli_dp.sv
module mli_dp
  import mli_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctsAsync,
  input  mliStrobe_t strb,
  input  logic       maskWrEn,
  input  logic       maskWrData,
  output logic       edgeSeen,
  output logic       statusQ,
  output logic       clrQ,
  output logic       maskedIrq
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] syncQ;
  logic          ctsPrev;
  logic          histValid;
  logic          maskQ;

  // Synchronizer chain: free-running so that it tracks the line during reset.
  always_ff @(posedge clk) begin
    syncQ[0] <= ctsAsync;
  end
  for (genvar g = 1; g < SYNC_STAGES; g++) begin : g_sync
    always_ff @(posedge clk) begin
      syncQ[g] <= syncQ[g-1];
    end
  end

  // Edge history follows the synchronized level, also while in reset.
  always_ff @(posedge clk) begin
    ctsPrev <= syncQ[LAST];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) histValid <= 1'b0;
    else        histValid <= 1'b1;
  end

  assign edgeSeen = histValid & (syncQ[LAST] ^ ctsPrev);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            statusQ <= 1'b0;
    else if (strb.setStat) statusQ <= 1'b1;
    else if (strb.clrStat) statusQ <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            clrQ <= 1'b0;
    else if (strb.loadClr) clrQ <= strb.clrVal;
    else if (strb.dropClr) clrQ <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        maskQ <= 1'b0;
    else if (maskWrEn) maskQ <= maskWrData;
  end

  assign maskedIrq = statusQ & maskQ;

  // R1: a detected change always leaves the status set
  p_edge_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
    edgeSeen |=> statusQ);
  // R7: masked output never exceeds raw status
  p_mask_sub_r7: assert property (@(posedge clk) disable iff (!rst_n)
    maskedIrq |-> statusQ);
endmodule

// File: rtl/modem_cts_irq.sv
module modem_cts_irq
  import mli_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ctsAsync,
  input  logic clrWrEn,
  input  logic clrWrData,
  input  logic maskWrEn,
  input  logic maskWrData,
  output logic rawIrq,
  output logic maskedIrq
);
  mliStrobe_t strb;
  logic       edgeSeen;
  logic       statusQ;
  logic       clrQ;

  mli_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .edgeSeen  (edgeSeen),
    .statusQ   (statusQ),
    .clrQ      (clrQ),
    .clrWrEn   (clrWrEn),
    .clrWrData (clrWrData),
    .strb      (strb)
  );

  mli_dp #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctsAsync   (ctsAsync),
    .strb       (strb),
    .maskWrEn   (maskWrEn),
    .maskWrData (maskWrData),
    .edgeSeen   (edgeSeen),
    .statusQ    (statusQ),
    .clrQ       (clrQ),
    .maskedIrq  (maskedIrq)
  );

  assign rawIrq = statusQ;
endmodule

// File: tb/tb_modem_cts_irq.sv
module tb_modem_cts_irq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctsAsync = 1'b1;
  logic clrWrEn = 1'b0, clrWrData = 1'b0;
  logic maskWrEn = 1'b0, maskWrData = 1'b0;
  logic rawIrq, maskedIrq;
  int   nChecks = 0;
  int   nErrors = 0;
  bit   done = 1'b0;

  always #5 clk = ~clk;

  modem_cts_irq dut (
    .clk(clk), .rst_n(rst_n), .ctsAsync(ctsAsync),
    .clrWrEn(clrWrEn), .clrWrData(clrWrData),
    .maskWrEn(maskWrEn), .maskWrData(maskWrData),
    .rawIrq(rawIrq), .maskedIrq(maskedIrq)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // One-cycle clear write; result visible at the following negedge.
  task automatic wrClr(input logic v);
    clrWrEn = 1'b1; clrWrData = v;
    @(negedge clk);
    clrWrEn = 1'b0; clrWrData = 1'b0;
  endtask

  task automatic wrMask(input logic v);
    maskWrEn = 1'b1; maskWrData = v;
    @(negedge clk);
    maskWrEn = 1'b0; maskWrData = 1'b0;
  endtask

  // Wait for a line change on ctsAsync to reach rawIrq (R1: three edges).
  task automatic toggleAndWait();
    ctsAsync = ~ctsAsync;
    idle(3);
  endtask

  initial begin
    // R8: CTS held high through reset must not produce an interrupt.
    idle(4);
    rst_n = 1'b1;
    chk("R8 raw after reset", rawIrq, 1'b0);
    chk("R8 masked after reset", maskedIrq, 1'b0);
    idle(6);
    chk("R8 no spurious edge from reset level", rawIrq, 1'b0);

    // R9: a constant line never sets the status.
    idle(20);
    chk("R9 constant line", rawIrq, 1'b0);

    // R8/R2: the hidden flop starts at 0, so a single write of 1 clears.
    toggleAndWait();
    chk("R1 falling change sets raw", rawIrq, 1'b1);
    wrClr(1'b1);
    chk("R2 first clear after reset", rawIrq, 1'b0);
    idle(2);

    // R4: hidden flop self-returns to 0, so the next single write clears.
    toggleAndWait();
    chk("R1 rising change sets raw", rawIrq, 1'b1);
    wrClr(1'b1);
    chk("R4 single write clears after self-reset", rawIrq, 1'b0);
    idle(2);

    // Sweep: clear-write offset relative to the line change, both directions.
    for (int dir = 0; dir < 2; dir++) begin
      for (int off = 0; off < 6; off++) begin
        bit locked;
        locked = (off == 2);   // write lands in the set cycle (R5)
        ctsAsync = ~ctsAsync;
        for (int c = 0; c < 6; c++) begin
          if (c == off) begin clrWrEn = 1'b1; clrWrData = 1'b1; end
          @(negedge clk);
          clrWrEn = 1'b0; clrWrData = 1'b0;
          if (c == 2)
            chk("R1 raw set at third edge", rawIrq, 1'b1);
        end
        // Expected raw after the sweep write: still set when the write came
        // before or with the set event; cleared when it came after (R2).
        chk(off <= 2 ? "R5 early/colliding write leaves raw set"
                     : "R2 write after set clears",
            rawIrq, (off <= 2) ? 1'b1 : 1'b0);
        idle(1);
        wrClr(1'b1);
        // Locked only on the collision; otherwise clearable (R3 vs R4).
        chk(locked ? "R5 lockup after collision" : "R4 second write result",
            rawIrq, 1'b0 ^ locked);
        wrClr(1'b1);
        if (locked) chk("R3 repeated 1 has no effect", rawIrq, 1'b1);
        // R6: write 0, hold, then write 1 recovers.
        wrClr(1'b0);
        idle(1);
        wrClr(1'b1);
        chk("R6 write 0 then 1 clears", rawIrq, 1'b0);
        idle(3);
      end
    end

    // R7: mask gates the output but not the raw status.
    toggleAndWait();
    chk("R7 raw with mask 0", rawIrq, 1'b1);
    chk("R7 masked with mask 0", maskedIrq, 1'b0);
    wrMask(1'b1);
    chk("R7 masked with mask 1", maskedIrq, 1'b1);
    wrMask(1'b0);
    chk("R7 mask clear keeps raw", rawIrq, 1'b1);
    chk("R7 masked off again", maskedIrq, 1'b0);
    wrMask(1'b1);
    wrClr(1'b1);
    chk("R7 masked follows raw clear", maskedIrq, 1'b0);
    idle(2);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        nChecks++;
        nErrors++;
        $display("FAIL watchdog: actual hung expected done");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end
endmodule